// File: doc/BRIEF.md
# Mode-Sampled Raster Line Timing Generator

This block generates the horizontal timing of one raster line for a bitmap video controller. A free-running position counter spans the line, and at a handful of fixed positions the block looks at two mode bits, a high-rate override and a 50/60 Hz rate select, to decide whether display-enable turns on, whether it ends at the normal right border, whether horizontal blank asserts, and where sync begins. The block drives display-enable, blank, hsync and a word-load strobe that tells the fetch logic when a 4-cycle word slot has completed.

Software may write either mode bit at any cycle through a one-bit write port. Each decision looks at the mode bits in only one cycle. A short mode pulse placed around that cycle therefore changes the geometry of the line: it can open the left border, hold display-enable past the right border, or suppress blanking so that the active area runs into the sync position.

Top module: `line_timing_gen`

## Requirements
- R1: The position counter runs 0 to 511 and wraps to 0, so every line lasts 512 cycles and the output pattern repeats each line.
- R2: During reset all outputs are low. Reset leaves the override off and the rate select at 50 Hz.
- R3: Every output changes in the cycle after the position whose decision moves it. With no mode writes, display-enable is high for positions 57 to 376.
- R4: If the override is on in position 4, display-enable is high from position 5.
- R5: If the rate select reads 50 Hz in position 372 and 60 Hz in position 376, the right-border end is skipped. Display-enable then stays high until blank asserts, or until sync if blank is also skipped. Any other pair of values ends display-enable after position 376.
- R6: Writes use wr_sel 0 for the override and wr_sel 1 for the rate select. wr_data 1 means override on or 60 Hz. An override write in cycle p is seen by decisions from p+1. A rate write in cycle p is seen from p+2.
- R7: If the override is off in position 450, blank is high from 451 to 511, and display-enable is forced low from 451. If the override is on there, blank stays low for that line. Blank is low at position 0 of every line.
- R8: hsync is high for positions 463 to 502 on every line, and display-enable is forced low from 463.
- R9: load_o pulses on the 4th, 8th, 12th and later cycles of each display-enable run. A partial slot at the end of a run gives no pulse, so a 458-cycle run gives 114 pulses.
- R10: display-enable and hsync are never high together, and load_o is never high while display-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode write strobe |
| wr_sel | input | 1 | 0 selects the override bit, 1 selects the rate select bit |
| wr_data | input | 1 | Value written: 1 means override on or 60 Hz |
| de_o | output | 1 | Display-enable |
| blank_o | output | 1 | Horizontal blank |
| hsync_o | output | 1 | Horizontal sync |
| load_o | output | 1 | Word-load strobe, one per completed 4-cycle slot |

## Verification
Two functions can act in the same cycle: blank assertion, and the end of a display-enable run that the rate pulse kept open. The bench provokes this with a rate pulse that lands exactly at position 376 while the override stays off at 450. It expects display-enable to fall at 451, the same position where blank rises, and it expects 98 loads from that shortened run. Its per-line record compares each edge position and the load count with values derived from the requirements. A second line adds override pulses at 4 and at 450, which moves the end of display-enable onto the sync edge at 463.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic {
    SEL_OVR  = 1'b0,
    SEL_RATE = 1'b1
  } mode_sel_e;

  typedef struct packed {
    logic de;
    logic blank;
    logic hsync;
  } line_out_t;

  // Right-border end is held when the rate went 50 -> 60 across the window.
  function automatic logic end_held(input logic rate_early, input logic rate_late);
    return !rate_early && rate_late;
  endfunction

  // A load fires on the last cycle of each completed word slot.
  function automatic logic load_due(input logic de, input logic slot_last);
    return de && slot_last;
  endfunction

endpackage

// File: rtl/lt_mode_regs.sv
module lt_mode_regs
  import lt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sel,
  input  logic wr_data,
  output logic ovr_q,
  output logic rate_q
);
  logic      rate_pend;
  mode_sel_e sel;

  assign sel = mode_sel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q     <= 1'b0;
      rate_pend <= 1'b0;
      rate_q    <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_OVR)  ovr_q     <= wr_data;
      if (wr_en && sel == SEL_RATE) rate_pend <= wr_data;
      rate_q <= rate_pend;
    end
  end
endmodule

// File: rtl/lt_line_counter.sv
module lt_line_counter #(
  parameter int unsigned LINE_LEN = 512,
  localparam int unsigned CW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (cnt == CW'(LINE_LEN - 1))   cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lt_enable_ctl.sv
module lt_enable_ctl
  import lt_pkg::*;
#(
  parameter int unsigned LINE_LEN   = 512,
  parameter int unsigned HI_START   = 4,
  parameter int unsigned DEF_START  = 56,
  parameter int unsigned END_EARLY  = 372,
  parameter int unsigned END_POS    = 376,
  parameter int unsigned BLANK_POS  = 450,
  parameter int unsigned SYNC_START = 462,
  parameter int unsigned SYNC_END   = 502,
  localparam int unsigned CW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          ovr,
  input  logic          rate,
  output line_out_t     outs,
  output logic          ev_left_open,
  output logic          ev_end_held,
  output logic          ev_blank_skip
);
  logic      rate_early_q;
  line_out_t cur_q, nxt;
  logic      at_start_hi, at_start_def, at_early, at_end, at_blank, at_sync, at_sync_end, at_last;

  assign at_start_hi  = (cnt == CW'(HI_START));
  assign at_start_def = (cnt == CW'(DEF_START));
  assign at_early     = (cnt == CW'(END_EARLY));
  assign at_end       = (cnt == CW'(END_POS));
  assign at_blank     = (cnt == CW'(BLANK_POS));
  assign at_sync      = (cnt == CW'(SYNC_START));
  assign at_sync_end  = (cnt == CW'(SYNC_END));
  assign at_last      = (cnt == CW'(LINE_LEN - 1));

  assign ev_left_open  = at_start_hi && ovr;
  assign ev_end_held   = at_end && end_held(rate_early_q, rate);
  assign ev_blank_skip = at_blank && ovr;

  always_comb begin
    nxt = cur_q;
    if (ev_left_open)              nxt.de = 1'b1;
    if (at_start_def)              nxt.de = 1'b1;
    if (at_end && !ev_end_held)    nxt.de = 1'b0;
    if (at_blank && !ovr) begin
      nxt.blank = 1'b1;
      nxt.de    = 1'b0;
    end
    if (at_sync) begin
      nxt.hsync = 1'b1;
      nxt.de    = 1'b0;
    end
    if (at_sync_end)               nxt.hsync = 1'b0;
    if (at_last)                   nxt.blank = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q        <= '0;
      rate_early_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      if (at_early) rate_early_q <= rate;
    end
  end

  assign outs = cur_q;
endmodule

// File: rtl/lt_load_gen.sv
module lt_load_gen
  import lt_pkg::*;
#(
  parameter int unsigned LOAD_DIV = 4,
  localparam int unsigned PW = (LOAD_DIV > 1) ? $clog2(LOAD_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic de,
  output logic load
);
  logic [PW-1:0] phase;
  logic          slot_last;

  assign slot_last = (phase == PW'(LOAD_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase <= '0;
    else if (!de)       phase <= '0;
    else if (slot_last) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  assign load = load_due(de, slot_last);
endmodule

// File: rtl/line_timing_gen.sv
module line_timing_gen
  import lt_pkg::*;
#(
  parameter int unsigned LINE_LEN   = 512,
  parameter int unsigned HI_START   = 4,
  parameter int unsigned DEF_START  = 56,
  parameter int unsigned END_EARLY  = 372,
  parameter int unsigned END_POS    = 376,
  parameter int unsigned BLANK_POS  = 450,
  parameter int unsigned SYNC_START = 462,
  parameter int unsigned SYNC_END   = 502,
  parameter int unsigned LOAD_DIV   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sel,
  input  logic wr_data,
  output logic de_o,
  output logic blank_o,
  output logic hsync_o,
  output logic load_o
);
  localparam int unsigned CW = $clog2(LINE_LEN);

  logic [CW-1:0] cnt;
  logic          ovr_q, rate_q;
  logic          ev_left_open, ev_end_held, ev_blank_skip;
  line_out_t     outs;

  lt_mode_regs u_modes (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ovr_q(ovr_q), .rate_q(rate_q)
  );

  lt_line_counter #(.LINE_LEN(LINE_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  lt_enable_ctl #(
    .LINE_LEN(LINE_LEN), .HI_START(HI_START), .DEF_START(DEF_START),
    .END_EARLY(END_EARLY), .END_POS(END_POS), .BLANK_POS(BLANK_POS),
    .SYNC_START(SYNC_START), .SYNC_END(SYNC_END)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .ovr(ovr_q), .rate(rate_q), .outs(outs),
    .ev_left_open(ev_left_open), .ev_end_held(ev_end_held), .ev_blank_skip(ev_blank_skip)
  );

  lt_load_gen #(.LOAD_DIV(LOAD_DIV)) u_load (
    .clk(clk), .rst_n(rst_n), .de(outs.de), .load(load_o)
  );

  assign de_o    = outs.de;
  assign blank_o = outs.blank;
  assign hsync_o = outs.hsync;
endmodule

// File: rtl/lt_chk.sv
module lt_chk #(
  parameter int unsigned LINE_LEN   = 512,
  parameter int unsigned HI_START   = 4,
  parameter int unsigned END_POS    = 376,
  parameter int unsigned BLANK_POS  = 450,
  parameter int unsigned SYNC_START = 462,
  parameter int unsigned CW         = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_sel,
  input logic          wr_data,
  input logic [CW-1:0] cnt,
  input logic          ovr_q,
  input logic          ev_left_open,
  input logic          ev_end_held,
  input logic          ev_blank_skip,
  input logic          de_o,
  input logic          blank_o,
  input logic          hsync_o,
  input logic          load_o
);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LINE_LEN - 1)) |=> (cnt == '0));

  // R4
  left_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_left_open |=> de_o);

  // R5
  end_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end_held && de_o) |=> de_o);

  // R5
  end_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CW'(END_POS)) && !ev_end_held) |=> !de_o);

  // R6
  ovr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ovr_q == $past(wr_data)));

  // R7
  blank_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blank_skip |=> !blank_o);

  // R7
  blank_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |-> (cnt == CW'(BLANK_POS + 1) && !de_o));

  // R8
  sync_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_o) |-> (cnt == CW'(SYNC_START + 1)));

  // R9
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R10
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(de_o && hsync_o));

  // R10
  load_in_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> de_o);

  // R4
  left_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(de_o) && $past(cnt) == CW'(HI_START)) |-> $past(ovr_q));
endmodule

bind line_timing_gen lt_chk #(
  .LINE_LEN(LINE_LEN), .HI_START(HI_START), .END_POS(END_POS),
  .BLANK_POS(BLANK_POS), .SYNC_START(SYNC_START), .CW(CW)
) u_lt_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt(cnt), .ovr_q(ovr_q), .ev_left_open(ev_left_open), .ev_end_held(ev_end_held),
  .ev_blank_skip(ev_blank_skip), .de_o(de_o), .blank_o(blank_o), .hsync_o(hsync_o),
  .load_o(load_o)
);

// File: tb/line_timing_gen_bench.sv
module line_timing_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, wr_sel, wr_data;
  logic de_o, blank_o, hsync_o, load_o;

  line_timing_gen u_line_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .de_o(de_o), .blank_o(blank_o), .hsync_o(hsync_o), .load_o(load_o)
  );

  typedef struct {
    int sid;
    int de_r;
    int de_f;
    int bl_r;
    int hs_r;
    int hs_f;
    int loads;
  } exp_t;

  exp_t sbq[$];
  int total = 0;
  int bad = 0;
  int pos = 0;
  int line = 0;

  task automatic chk(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Position model: line of 512 cycles, position 0 in the first cycle after reset.
  always @(posedge clk) begin
    if (!rst_n) begin
      pos  <= 0;
      line <= 0;
    end else if (pos == 511) begin
      pos  <= 0;
      line <= line + 1;
    end else begin
      pos <= pos + 1;
    end
  end

  // Expected line record from the requirement text.
  function automatic exp_t expect_line(input int sid, input bit left, input bit held, input bit noblank);
    exp_t e;
    e.sid   = sid;
    e.de_r  = left ? 5 : 57;
    if (!held)        e.de_f = 377;
    else if (!noblank) e.de_f = 451;
    else              e.de_f = 463;
    e.bl_r  = noblank ? -1 : 451;
    e.hs_r  = 463;
    e.hs_f  = 503;
    e.loads = (e.de_f - e.de_r) / 4;
    return e;
  endfunction

  // Monitor: observed record per line.
  int o_de_r, o_de_f, o_bl_r, o_hs_r, o_hs_f, o_loads, o_clash;
  logic p_de = 1'b0, p_bl = 1'b0, p_hs = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pos == 0) begin
        chk("R7", "blank at position 0", int'(blank_o), 0);
        o_de_r = -1; o_de_f = -1; o_bl_r = -1; o_hs_r = -1; o_hs_f = -1;
        o_loads = 0; o_clash = 0;
      end
      if (de_o && !p_de) o_de_r = pos;
      if (!de_o && p_de) o_de_f = pos;
      if (blank_o && !p_bl) o_bl_r = pos;
      if (hsync_o && !p_hs) o_hs_r = pos;
      if (!hsync_o && p_hs) o_hs_f = pos;
      if (load_o) o_loads++;
      if ((de_o && hsync_o) || (load_o && !de_o)) o_clash++;
      p_de = de_o; p_bl = blank_o; p_hs = hsync_o;
      if (pos == 511 && sbq.size() > 0) begin
        exp_t e;
        string tag;
        e = sbq.pop_front();
        tag = $sformatf("line-case %0d", e.sid);
        chk("R3/R4", {tag, " de rise"}, o_de_r, e.de_r);
        chk("R5", {tag, " de fall"}, o_de_f, e.de_f);
        chk("R7", {tag, " blank rise"}, o_bl_r, e.bl_r);
        chk("R1/R8", {tag, " hsync rise"}, o_hs_r, e.hs_r);
        chk("R8", {tag, " hsync fall"}, o_hs_f, e.hs_f);
        chk("R9", {tag, " load count"}, o_loads, e.loads);
        chk("R10", {tag, " overlap cycles"}, o_clash, 0);
      end
    end
  end

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (pos != p) @(negedge clk);
  endtask

  task automatic wr(input int p, input bit sel, input bit d);
    wait_pos(p);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic begin_line(input exp_t e);
    wait_pos(0);
    sbq.push_back(e);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "reset de", int'(de_o), 0);
    chk("R2", "reset blank", int'(blank_o), 0);
    chk("R2", "reset hsync", int'(hsync_o), 0);
    chk("R2", "reset load", int'(load_o), 0);
    rst_n = 1'b1;

    // R2/R3: first line after reset uses default geometry
    sbq.push_back(expect_line(0, 0, 0, 0));
    // R4: override pulse covering position 4
    begin_line(expect_line(1, 1, 0, 0));
    wr(2, 1'b0, 1'b1); wr(6, 1'b0, 1'b0);
    // R5 R6: rate write at 374 lands at 376 -> end held, blank ends de at 451
    begin_line(expect_line(2, 0, 1, 0));
    wr(374, 1'b1, 1'b1); wr(382, 1'b1, 1'b0);
    // R6: rate write at 375 arrives too late -> normal end
    begin_line(expect_line(3, 0, 0, 0));
    wr(375, 1'b1, 1'b1); wr(385, 1'b1, 1'b0);
    // R4 R5 R7 R9: all three widening pulses, 458-cycle run, 114 loads
    begin_line(expect_line(4, 1, 1, 1));
    wr(3, 1'b0, 1'b1); wr(5, 1'b0, 1'b0);
    wr(372, 1'b1, 1'b1); wr(380, 1'b1, 1'b0);
    wr(449, 1'b0, 1'b1); wr(455, 1'b0, 1'b0);
    // R6: override written at 4 is seen from 5 -> left border stays closed
    begin_line(expect_line(5, 0, 0, 0));
    wr(4, 1'b0, 1'b1); wr(8, 1'b0, 1'b0);
    // R5: steady 60 Hz across the window does not hold the end
    begin_line(expect_line(6, 0, 0, 0));
    wr(100, 1'b1, 1'b1);
    begin_line(expect_line(7, 0, 0, 0));
    wr(400, 1'b1, 1'b0);
    // R7: override at 450 only -> no blank this line
    begin_line(expect_line(8, 0, 0, 1));
    wr(449, 1'b0, 1'b1); wr(455, 1'b0, 1'b0);
    // R1 R7: following line is back to default
    begin_line(expect_line(9, 0, 0, 0));

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule